// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a 16-bit down-counting interval timer for a small on-chip peripheral bus. Software programs it through three 16-bit registers: a control/status word, a modulus (limit) word and a read-only view of the live count. The count is advanced by a tick derived from the system clock. The system clock is first halved, then divided by a power of two that the control word selects. The divide ranges from 2 to 65536 system clocks per tick.

When the count passes zero, the block raises a sticky expiry flag and reloads the counter. The reload value is either the modulus or the full-scale value 0xFFFF, as the control word selects. A level interrupt is driven while the flag and the interrupt-enable bit are both set. Software clears the flag by writing a one to it. A write to the modulus register also clears the flag. With the overwrite bit set, a modulus write also forces the new limit into the counter at once.

A control write that alters anything other than the interrupt-enable bit stops the count and clears the divider. It then restarts the count from the selected limit. A write that touches only the interrupt-enable bit leaves counting undisturbed. The debug and doze bits are stored and read back but have no effect.

Top module: `interval_timer`

## Requirements
- R1: After reset the control word and the modulus read 0, the count reads 0xFFFF and irq is low.
- R2: While bit0 (run) of the control word is 1, the counter takes one step every 2^(N+1) clock cycles. N is bits 11:8 of the control word.
- R3: On each step a non-zero count decrements. A zero count reloads: to 0xFFFF when bit1 (full-scale) is 1, and to the modulus when bit1 is 0.
- R4: Bit2 of the control word is the expiry flag. Writing 1 there clears it, writing 0 leaves it, and no write can set it.
- R5: A step taken at count zero sets the flag. An expiry wins over a clear in the same cycle.
- R6: irq is high exactly when the registered flag and bit3 (interrupt enable) are both 1. It follows any write or expiry by one cycle.
- R7: A control write whose only difference from the stored word is in bit3 and/or bit2 leaves the count and the divider running undisturbed.
- R8: A control write that changes any of bits 0, 1, 4, 5, 6 or 11:8 clears the divider. It loads the counter with the limit selected by the new bit1. Counting resumes only if the new bit0 is 1.
- R9: A write to offset 2 stores the modulus and clears the flag. If bit4 (overwrite) is set, it also loads the counter with the new limit (0xFFFF under full-scale) and clears the divider. Otherwise the count is untouched.
- R10: Writes to offset 4 (count) and to unmapped offsets change no state.
- R11: While bit0 is 0, the count and the divider hold their values.
- R12: A read strobe returns data on the cycle after it. Offset 0 returns the control word with bits 7 and 15:12 as 0, offset 2 the modulus, offset 4 the count, and other offsets 0. Between reads the data holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench checks several corner cases:
- Expiry in the same cycle as a flag clear. A design that lets the clear win would drop an interrupt.
- A control write that only toggles interrupt enable. A design that restarts here would show a count snapped back to the limit.
- A modulus write with and without overwrite. A design that gets this wrong would change the count too early, or never.
- Reload under both full-scale settings, and prescale values above zero. A design with an off-by-one divider would read counts that drift from the model's.
- A long mixed sequence of writes to every offset, including the read-only count. This shows whether stray writes corrupt state.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 4;

  localparam logic [ADDR_W-1:0] OFF_CTL = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MOD = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CNT = 3'd4;

  // Bit positions in the control word; software decodes these.
  localparam int B_RUN  = 0;
  localparam int B_FULL = 1;
  localparam int B_FLAG = 2;
  localparam int B_IEN  = 3;
  localparam int B_OVW  = 4;
  localparam int B_DBG  = 5;
  localparam int B_DOZE = 6;
  localparam int B_PRE  = 8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             doze;
    logic             dbg;
    logic             ovw;
    logic             ien;
    logic             full;
    logic             run;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.pre  = w[B_PRE +: PRE_W];
    c.doze = w[B_DOZE];
    c.dbg  = w[B_DBG];
    c.ovw  = w[B_OVW];
    c.ien  = w[B_IEN];
    c.full = w[B_FULL];
    c.run  = w[B_RUN];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_PRE +: PRE_W] = c.pre;
    w[B_DOZE] = c.doze;
    w[B_DBG]  = c.dbg;
    w[B_OVW]  = c.ovw;
    w[B_IEN]  = c.ien;
    w[B_FLAG] = flag;
    w[B_FULL] = c.full;
    w[B_RUN]  = c.run;
    return w;
  endfunction
endpackage

// File: rtl/itimer_regs.sv
module itimer_regs
  import itimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output ctrl_t             cfg_o,
  output logic [CNT_W-1:0]  mod_o,
  output logic              flag_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  localparam logic [CNT_W-1:0] FULL_SCALE = {CNT_W{1'b1}};

  ctrl_t            cfg_q, cfg_d, cfg_new;
  logic [CNT_W-1:0] mod_q, mod_d;
  logic             flag_q, flag_d;
  logic             wr_ctl, wr_mod, restart, ovw_load, clr_req;

  always_comb begin
    wr_ctl  = wr && (addr == OFF_CTL);
    wr_mod  = wr && (addr == OFF_MOD);
    cfg_new = unpack_ctrl(wdata);
    restart = wr_ctl &&
              ({cfg_new.pre, cfg_new.doze, cfg_new.dbg, cfg_new.ovw, cfg_new.full, cfg_new.run} !=
               {cfg_q.pre,   cfg_q.doze,   cfg_q.dbg,   cfg_q.ovw,   cfg_q.full,   cfg_q.run});
    ovw_load = wr_mod && cfg_q.ovw;
    clr_req  = wr_mod || (wr_ctl && wdata[B_FLAG]);

    cfg_d  = wr_ctl ? cfg_new : cfg_q;
    mod_d  = wr_mod ? wdata[CNT_W-1:0] : mod_q;
    flag_d = expire ? 1'b1 : (clr_req ? 1'b0 : flag_q);

    load_o = restart || ovw_load;
    if (restart)
      load_val_o = cfg_new.full ? FULL_SCALE : mod_q;
    else
      load_val_o = cfg_q.full ? FULL_SCALE : wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mod_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      mod_q  <= mod_d;
      flag_q <= flag_d;
    end
  end

  assign cfg_o  = cfg_q;
  assign mod_o  = mod_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/itimer_prescale.sv
module itimer_prescale
  import itimer_pkg::*;
#(
  parameter int SEL_W = PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             tick,
  output logic [(1<<SEL_W)-1:0] div_o
);
  localparam int DIV_W = 1 << SEL_W;

  logic [DIV_W-1:0] div_q, div_d, term;

  // Terminal value 2^(sel+1)-1: bits 0..sel set.
  always_comb begin
    for (int i = 0; i < DIV_W; i++)
      term[i] = (i <= int'(sel));
  end

  always_comb begin
    tick  = run && (div_q == term);
    div_d = div_q;
    if (clear)
      div_d = '0;
    else if (run)
      div_d = tick ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign div_o = div_q;
endmodule

// File: rtl/itimer_counter.sv
module itimer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             full,
  input  logic [CNT_W-1:0] mod,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire
);
  localparam logic [CNT_W-1:0] FULL_SCALE = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             step, at_zero;

  always_comb begin
    limit   = full ? FULL_SCALE : mod;
    at_zero = (cnt_q == '0);
    step    = run && tick && !load;
    expire  = step && at_zero;
    cnt_d   = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (step)
      cnt_d = at_zero ? limit : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= FULL_SCALE;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int DIV_W = 1 << PRE_W;

  logic [1:0]        rs_q;
  logic              rst_n_int;
  ctrl_t             cfg;
  logic [CNT_W-1:0]  mod, cnt_q, load_val;
  logic              flag, load, tick, expire;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] rdata_q, rdata_d, rd_mux;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_int = rs_q[1];

  itimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .expire     (expire),
    .cfg_o      (cfg),
    .mod_o      (mod),
    .flag_o     (flag),
    .load_o     (load),
    .load_val_o (load_val)
  );

  itimer_prescale #(.SEL_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (cfg.run),
    .clear (load),
    .sel   (cfg.pre),
    .tick  (tick),
    .div_o (div_q)
  );

  itimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .run      (cfg.run),
    .tick     (tick),
    .full     (cfg.full),
    .mod      (mod),
    .load     (load),
    .load_val (load_val),
    .cnt_o    (cnt_q),
    .expire   (expire)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_CTL: rd_mux = pack_ctrl(cfg, flag);
      OFF_MOD: rd_mux = DATA_W'(mod);
      OFF_CNT: rd_mux = DATA_W'(cnt_q);
      default: rd_mux = '0;
    endcase
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) rdata_q <= '0;
    else            rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign irq       = flag & cfg.ien;
endmodule

// File: rtl/itimer_chk.sv
module itimer_chk
  import itimer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input ctrl_t             cfg,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  mod,
  input logic [DIV_W-1:0]  div,
  input logic              tick,
  input logic              load,
  input logic              expire,
  input logic              flag,
  input logic              irq
);
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.run && tick && !load && cnt != '0) |=> (cnt + 1'b1) == $past(cnt));

  p_wrap_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && cfg.full) |=> cnt == {CNT_W{1'b1}});

  p_reload_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !cfg.full) |=> cnt == $past(mod));

  p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !expire) |=> !flag);

  p_expire_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.ien |-> !irq);

  p_mod_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_MOD && !expire) |=> !flag);

  p_count_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == OFF_CNT && !cfg.run) |=> $stable(cnt));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.run && !load) |=> ($stable(cnt) && $stable(div)));
endmodule

bind interval_timer itimer_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_int),
  .wr     (bus_wr),
  .addr   (bus_addr),
  .cfg    (cfg),
  .cnt    (cnt_q),
  .mod    (mod),
  .div    (div_q),
  .tick   (tick),
  .load   (load),
  .expire (expire),
  .flag   (flag),
  .irq    (irq)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit started = 0;
  string cur_tag = "R12";

  // reference model state
  int m_cnt, m_pre, m_mod, m_ctl, m_flag, m_rdata;
  bit m_rdv;
  string m_rdtag;

  always #5 clk = ~clk;

  interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Behavioural reference, one update per rising edge.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 65535; m_pre = 0; m_mod = 0; m_ctl = 0; m_flag = 0;
      m_rdata = 0; m_rdv = 0;
    end else begin
      bit run, full, tick, restart, ovw, expire;
      int sel, limit, wd;
      wd   = int'(bus_wdata);
      m_rdv = bus_rd;
      if (bus_rd) begin
        m_rdtag = cur_tag;
        case (bus_addr)
          3'd0: m_rdata = m_ctl | (m_flag << 2);
          3'd2: m_rdata = m_mod;
          3'd4: m_rdata = m_cnt;
          default: m_rdata = 0;
        endcase
      end
      run   = m_ctl[0];
      full  = m_ctl[1];
      sel   = (m_ctl >> 8) & 15;
      tick  = run && (m_pre == (2 << sel) - 1);
      limit = full ? 65535 : m_mod;
      restart = bus_wr && bus_addr == 3'd0 && ((wd & 'h0F73) != (m_ctl & 'h0F73));
      ovw     = bus_wr && bus_addr == 3'd2 && m_ctl[4];
      expire  = tick && m_cnt == 0 && !restart && !ovw;
      if (restart) begin
        m_cnt = wd[1] ? 65535 : m_mod; m_pre = 0;
      end else if (ovw) begin
        m_cnt = full ? 65535 : wd; m_pre = 0;
      end else if (run) begin
        if (tick) begin
          m_pre = 0;
          m_cnt = (m_cnt == 0) ? limit : m_cnt - 1;
        end else m_pre++;
      end
      if (bus_wr && bus_addr == 3'd0 && wd[2]) m_flag = 0;
      if (bus_wr && bus_addr == 3'd2) m_flag = 0;
      if (expire) m_flag = 1;
      if (bus_wr && bus_addr == 3'd0) m_ctl = wd & 'h0F7B;
      if (bus_wr && bus_addr == 3'd2) m_mod = wd;
    end
  end

  // Compare away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      int exp_irq;
      exp_irq = (m_flag != 0 && m_ctl[3]) ? 1 : 0;
      check(int'(irq) == exp_irq, "R6", int'(irq), exp_irq);
      if (m_rdv)
        check(int'(bus_rdata) == m_rdata, m_rdtag, int'(bus_rdata), m_rdata);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk);
    cur_tag = tag; bus_addr = a; bus_rd = 1; bus_wr = 0;
    @(negedge clk);
    bus_rd = 0;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 190000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int unsigned seed = 32'h1234_5678;
  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    started = 1;
    // R1 reset state
    rd(3'd0, "R1"); rd(3'd2, "R1"); rd(3'd4, "R1");
    check(irq == 1'b0, "R1", int'(irq), 0);

    // R2/R3: modulus 5, run + interrupt enable, prescale 0
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h0009);
    for (int i = 0; i < 20; i++) rd(3'd4, "R3");
    rd(3'd0, "R5");
    // R4: writing 0 to flag leaves it, writing 1 clears
    wr(3'd0, 16'h0009);
    rd(3'd0, "R4");
    wr(3'd0, 16'h000D);
    rd(3'd0, "R4");
    // R7: interrupt-enable-only toggles keep the count running
    rd(3'd4, "R7");
    wr(3'd0, 16'h0001);
    rd(3'd4, "R7");
    wr(3'd0, 16'h0009);
    rd(3'd4, "R7");
    // R2: prescale N=2 (restart), count steps every 8 cycles
    wr(3'd0, 16'h0209);
    for (int i = 0; i < 40; i++) rd(3'd4, "R2");
    // R8: full-scale restart loads 0xFFFF
    wr(3'd0, 16'h000B);
    rd(3'd4, "R8"); rd(3'd4, "R8");
    // R9: modulus write without overwrite leaves the count
    wr(3'd0, 16'h0009);
    idle(20);
    wr(3'd2, 16'd3);
    rd(3'd0, "R9"); rd(3'd4, "R9");
    // R9: with overwrite the count loads at once
    wr(3'd0, 16'h0019);
    wr(3'd2, 16'd7);
    rd(3'd4, "R9"); rd(3'd2, "R9");
    // R10: writes to the count and unmapped offsets are ignored
    wr(3'd4, 16'h1234);
    rd(3'd4, "R10");
    wr(3'd6, 16'hFFFF);
    rd(3'd0, "R10"); rd(3'd2, "R10");
    // R11: stop and hold
    wr(3'd0, 16'h0018);
    rd(3'd4, "R11"); idle(10); rd(3'd4, "R11");
    // R12: upper/stray bits read back as 0, unmapped read 0
    wr(3'd0, 16'hF0F8);
    rd(3'd0, "R12"); rd(3'd6, "R12");
    // Mixed sequence: races of expiry vs clear (R5), reloads (R3)
    for (int i = 0; i < 6000; i++) begin
      int unsigned r, k;
      r = nxt();
      k = r % 10;
      if (k < 3) rd(3'(2 * ((r >> 4) % 4)), "R5");
      else if (k < 5) wr(3'd0, 16'((r >> 4) & 16'h017F));
      else if (k < 7) wr(3'd2, 16'((r >> 4) % 8));
      else if (k < 8) wr(3'd4, 16'(r >> 4));
      else idle(int'((r >> 4) % 6));
    end
    rd(3'd4, "R3");
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule